// File: doc/BRIEF.md
# DRAM Bank Select and Common-Area Override

This block lets an 8-bit CPU with a 16-bit address bus reach 256 KB of DRAM. Four 64 KB banks sit behind one extra multiplexed DRAM address line. A small configuration register lives at two positions inside the expansion I/O strobe window. A write picks the bank with two bits and switches two shared windows on or off. A read returns those four bits together with four general-purpose user inputs.

The extra DRAM address pin carries the low bank bit in one address phase and the high bank bit in the other. The phase is chosen by the board's existing row/column select. Each of the two shared windows can be enabled on its own: a low one at $0000-$03FF and a high one at $C000-$C7FF. When the CPU touches an enabled window, the extra pin is held low, so bank 0 is reached whatever bank is selected. Stack and shared variables therefore stay visible from every bank.

A preserve switch decides whether a system reset wipes the configuration. A separate clear input wipes the register alone.

Top module: `dram_bank_ctl`

## Requirements
- R1: The configuration register is written only when all of the following hold: `io_sel_n` is low, `cpu_rw` is low, and `cpu_addr[7:5]` is 3'b110. The value is captured on the clock edge that first sees `phi2` low after it was high, and it is visible from the following cycle.
- R2: Written data bits map as follows: bit 0 is bank bit 0, bit 1 is bank bit 1, bit 2 enables the low window and bit 3 enables the high window. Bits 7:4 are discarded.
- R3: While `io_sel_n` is low, `cpu_rw` is high and `cpu_addr[7:5]` is 3'b111, `rd_oe` is high. In that case `cpu_rdata` presents `user_in` on bits 7:4 and the four stored configuration bits on bits 3:0, in the R2 order. In every other case `rd_oe` is low.
- R4: A `phi2` fall with any other select code, with `cpu_rw` high, or with `io_sel_n` high leaves the stored configuration unchanged.
- R5: Outside an enabled window, `ma8` equals bank bit 0 while `mux_sel` is low and bank bit 1 while `mux_sel` is high.
- R6: With the low window enabled, `ma8` is 0 for any `cpu_addr` in $0000-$03FF; $0400 is not overridden.
- R7: With the high window enabled, `ma8` is 0 for any `cpu_addr` in $C000-$C7FF; $BFFF and $C800 are not overridden.
- R8: A window whose enable bit is 0 never overrides `ma8`.
- R9: A cycle with `rst_n` low clears the configuration to 0 when `keep_cfg` is 0 and leaves it unchanged when `keep_cfg` is 1.
- R10: A cycle with `clr_n` low clears the configuration to 0 whatever `keep_cfg` and `rst_n` are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| keep_cfg | input | 1 | Preserve switch: 1 keeps the configuration across `rst_n` |
| clr_n | input | 1 | Synchronous active-low clear of the configuration only |
| phi2 | input | 1 | CPU phase-2 clock level, sampled by `clk` |
| io_sel_n | input | 1 | Expansion I/O strobe, active low |
| cpu_rw | input | 1 | CPU read (1) / write (0) |
| cpu_addr | input | 16 | CPU address bus |
| cpu_wdata | input | 8 | CPU write data |
| user_in | input | 4 | User inputs returned on a read (pulled high on the board) |
| mux_sel | input | 1 | DRAM address phase select |
| cpu_rdata | output | 8 | Read-back data |
| rd_oe | output | 1 | Read-back data valid / drive enable |
| ma8 | output | 1 | Extra multiplexed DRAM address line |

## Verification
A corrupted configuration bit shows up on `ma8` in the same cycle for every address outside an enabled window, in the phase that carries that bit. It also shows up on `cpu_rdata` at the next read. A wrong window bound or a wrong enable shows as a non-zero `ma8` exactly at the window edge addresses, or as a zero just outside them. A wrong reset or clear path is visible on the first read after the pulse.

// File: rtl/bank_pkg.sv
// Package: shared configuration type for the DRAM bank selector.
// Assumes the stored configuration is exactly four bits wide.
package bank_pkg;

    // Stored configuration; bit 0 is bank bit 0, bit 3 is the high window enable
    typedef struct packed {
        logic hi_en;
        logic lo_en;
        logic bank1;
        logic bank0;
    } bank_cfg_t;

    localparam int CFG_W = $bits(bank_cfg_t);

endpackage

// File: rtl/bank_reg_decode.sv
// Module: bank_reg_decode
// Turns the I/O strobe, the direction and the select field into write-hit
// and read-hit flags. Assumes io_sel_n is already qualified by the board.
module bank_reg_decode #(
    parameter int              SEL_W   = 3,
    parameter logic [SEL_W-1:0] WR_CODE = 3'b110,
    parameter logic [SEL_W-1:0] RD_CODE = 3'b111
) (
    input  logic             io_sel_n,
    input  logic             cpu_rw,
    input  logic [SEL_W-1:0] sel,
    output logic             wr_hit,
    output logic             rd_hit
);

    // Purpose: compare the select field against the two register codes
    always_comb begin
        wr_hit = !io_sel_n && !cpu_rw && (sel == WR_CODE);
        rd_hit = !io_sel_n &&  cpu_rw && (sel == RD_CODE);
    end

endmodule

// File: rtl/bank_cfg_latch.sv
// Module: bank_cfg_latch
// Holds the bank bits and window enables. Loads on the first clk edge that
// sees phi2 low after high while a write hit is present. Assumes phi2 is
// already synchronous to clk.
module bank_cfg_latch
    import bank_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      keep_cfg,
    input  logic      clr_n,
    input  logic      phi2,
    input  logic      wr_hit,
    input  bank_cfg_t wr_cfg,
    output bank_cfg_t cfg
);

    logic phi2_q;
    logic phi2_fall;
    logic cfg_clear;

    assign phi2_fall = phi2_q && !phi2;
    assign cfg_clear = !clr_n || (!rst_n && !keep_cfg);

    // Purpose: remember the previous phi2 level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) phi2_q <= 1'b0;
        else        phi2_q <= phi2;
    end

    // Purpose: clear, preserve or load the configuration
    always_ff @(posedge clk) begin
        if (cfg_clear)                        cfg <= '0;
        else if (rst_n && wr_hit && phi2_fall) cfg <= wr_cfg;
    end

    // R9: reset with preserve off empties the register
    a_r9_reset_clears: assert property (@(posedge clk)
        (!rst_n && !keep_cfg) |=> (cfg == '0));

    // R9: reset with preserve on keeps the register
    a_r9_reset_keeps: assert property (@(posedge clk) disable iff (!clr_n)
        (!rst_n && keep_cfg && $past(rst_n)) |=> $stable(cfg));

    // R10: the clear input always empties the register
    a_r10_clear_only: assert property (@(posedge clk)
        (!clr_n) |=> (cfg == '0));

    // R4: without a qualified write the register holds
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        !(wr_hit && phi2_fall) |=> $stable(cfg));

endmodule

// File: rtl/common_area_match.sv
// Module: common_area_match
// Flags an access inside one enabled shared window [BASE, LAST].
// Assumes BASE <= LAST.
module common_area_match #(
    parameter int                ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE   = '0,
    parameter logic [ADDR_W-1:0] LAST   = '0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              en,
    output logic              hit
);

    // Purpose: range compare gated by the window enable
    always_comb hit = en && (addr >= BASE) && (addr <= LAST);

endmodule

// File: rtl/ma8_mux.sv
// Module: ma8_mux
// Two-way selector for the extra DRAM address line. When disabled it
// drives low, which selects bank 0.
module ma8_mux (
    input  logic bank0,
    input  logic bank1,
    input  logic mux_sel,
    input  logic dis,
    output logic ma8
);

    // Purpose: phase select with a forced-low disable
    always_comb ma8 = dis ? 1'b0 : (mux_sel ? bank1 : bank0);

endmodule

// File: rtl/dram_bank_ctl.sv
// Module: dram_bank_ctl
// Top of the bank selector: register decode, configuration store,
// shared-window detection and extra DRAM address line generation.
// Assumes all inputs are synchronous to clk.
module dram_bank_ctl
    import bank_pkg::*;
#(
    parameter int                ADDR_W  = 16,
    parameter int                DATA_W  = 8,
    parameter int                USER_W  = 4,
    parameter int                SEL_LSB = 5,
    parameter int                SEL_W   = 3,
    parameter logic [SEL_W-1:0]  WR_CODE = 3'b110,
    parameter logic [SEL_W-1:0]  RD_CODE = 3'b111,
    parameter logic [ADDR_W-1:0] LO_BASE = 16'h0000,
    parameter logic [ADDR_W-1:0] LO_LAST = 16'h03FF,
    parameter logic [ADDR_W-1:0] HI_BASE = 16'hC000,
    parameter logic [ADDR_W-1:0] HI_LAST = 16'hC7FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              keep_cfg,
    input  logic              clr_n,
    input  logic              phi2,
    input  logic              io_sel_n,
    input  logic              cpu_rw,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic [USER_W-1:0] user_in,
    input  logic              mux_sel,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              rd_oe,
    output logic              ma8
);

    localparam int NUM_AREAS = 2;
    localparam logic [ADDR_W-1:0] AREA_BASE [NUM_AREAS] = '{LO_BASE, HI_BASE};
    localparam logic [ADDR_W-1:0] AREA_LAST [NUM_AREAS] = '{LO_LAST, HI_LAST};

    logic                 wr_hit;
    logic                 rd_hit;
    bank_cfg_t            cfg;
    logic [NUM_AREAS-1:0] area_en;
    logic [NUM_AREAS-1:0] area_hit;
    logic                 common_hit;

    bank_reg_decode #(
        .SEL_W   (SEL_W),
        .WR_CODE (WR_CODE),
        .RD_CODE (RD_CODE)
    ) dec_i (
        .io_sel_n (io_sel_n),
        .cpu_rw   (cpu_rw),
        .sel      (cpu_addr[SEL_LSB +: SEL_W]),
        .wr_hit   (wr_hit),
        .rd_hit   (rd_hit)
    );

    bank_cfg_latch cfg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .keep_cfg (keep_cfg),
        .clr_n    (clr_n),
        .phi2     (phi2),
        .wr_hit   (wr_hit),
        .wr_cfg   (bank_cfg_t'(cpu_wdata[CFG_W-1:0])),
        .cfg      (cfg)
    );

    assign area_en = {cfg.hi_en, cfg.lo_en};

    // One range comparator per shared window
    for (genvar g = 0; g < NUM_AREAS; g++) begin : g_area
        common_area_match #(
            .ADDR_W (ADDR_W),
            .BASE   (AREA_BASE[g]),
            .LAST   (AREA_LAST[g])
        ) match_i (
            .addr (cpu_addr),
            .en   (area_en[g]),
            .hit  (area_hit[g])
        );
    end

    assign common_hit = |area_hit;

    ma8_mux mux_i (
        .bank0   (cfg.bank0),
        .bank1   (cfg.bank1),
        .mux_sel (mux_sel),
        .dis     (common_hit),
        .ma8     (ma8)
    );

    // Purpose: assemble read-back data and its enable
    always_comb begin
        cpu_rdata = '0;
        cpu_rdata[CFG_W-1:0] = cfg;
        cpu_rdata[CFG_W +: USER_W] = user_in;
        rd_oe = rd_hit;
    end

    // R6 R7: an access to an enabled window keeps the extra line low
    a_r6_r7_override: assert property (@(posedge clk) disable iff (!rst_n)
        common_hit |-> !ma8);

    // R3: read data is only enabled during a read of the read-back code
    a_r3_oe_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        rd_oe |-> (!io_sel_n && cpu_rw));

    // R1: write and read hits are mutually exclusive
    a_r1_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_hit, rd_hit}));

    // R8: without enables the extra line follows the bank bits
    a_r8_no_override: assert property (@(posedge clk) disable iff (!rst_n)
        (area_en == '0) |-> (ma8 == (mux_sel ? cfg.bank1 : cfg.bank0)));

endmodule

// File: tb/dram_bank_ctl_tb_top.sv
// Directed bench for dram_bank_ctl; one task per scenario.
module dram_bank_ctl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        keep_cfg = 1'b0;
    logic        clr_n = 1'b1;
    logic        phi2 = 1'b1;
    logic        io_sel_n = 1'b1;
    logic        cpu_rw = 1'b1;
    logic [15:0] cpu_addr = 16'h8000;
    logic [7:0]  cpu_wdata = 8'h00;
    logic [3:0]  user_in = 4'hF;
    logic        mux_sel = 1'b0;
    logic [7:0]  cpu_rdata;
    logic        rd_oe;
    logic        ma8;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;   // 250 MHz

    dram_bank_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .keep_cfg(keep_cfg), .clr_n(clr_n),
        .phi2(phi2), .io_sel_n(io_sel_n), .cpu_rw(cpu_rw),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .user_in(user_in),
        .mux_sel(mux_sel), .cpu_rdata(cpu_rdata), .rd_oe(rd_oe), .ma8(ma8)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Bus write: phi2 high with write set up, then phi2 falls
    task automatic bus_write(input logic [15:0] a, input logic [7:0] d,
                             input logic sel_n, input logic rw);
        @(negedge clk);
        io_sel_n = sel_n; cpu_rw = rw; cpu_addr = a; cpu_wdata = d; phi2 = 1'b1;
        @(negedge clk);
        phi2 = 1'b0;
        @(negedge clk);
        phi2 = 1'b1; io_sel_n = 1'b1; cpu_rw = 1'b1; cpu_addr = 16'h8000;
    endtask

    // Read-back of the register; returns data, checks the enable
    task automatic bus_read(output logic [7:0] d);
        @(negedge clk);
        io_sel_n = 1'b0; cpu_rw = 1'b1; cpu_addr = 16'hDEE0;
        #1;
        chk("R3 rd_oe", {7'd0, rd_oe}, 8'h01);
        d = cpu_rdata;
        io_sel_n = 1'b1; cpu_addr = 16'h8000;
        #1;
        chk("R3 rd_oe idle", {7'd0, rd_oe}, 8'h00);
    endtask

    function automatic logic exp_ma8(input logic [3:0] c, input logic [15:0] a,
                                     input logic s);
        if (c[2] && a <= 16'h03FF) return 1'b0;
        if (c[3] && a >= 16'hC000 && a <= 16'hC7FF) return 1'b0;
        return s ? c[1] : c[0];
    endfunction

    task automatic t_reset_state();
        logic [7:0] d;
        bus_read(d);
        chk("R9 reset value", d, 8'hF0);
    endtask

    task automatic t_readback();
        logic [7:0] d;
        bus_write(16'hDEC0, 8'hA5, 1'b0, 1'b0);   // R2: upper nibble dropped
        user_in = 4'h6;
        bus_read(d);
        chk("R1 R2 R3 readback", d, 8'h65);
        bus_write(16'hDEC0, 8'h0A, 1'b0, 1'b0);
        user_in = 4'h9;
        bus_read(d);
        chk("R2 R3 readback", d, 8'h9A);
        user_in = 4'hF;
    endtask

    task automatic t_ignored();
        logic [7:0] d;
        bus_write(16'hDEC0, 8'h03, 1'b0, 1'b0);
        bus_write(16'hDEA0, 8'h0C, 1'b0, 1'b0);   // wrong code
        bus_write(16'hDEE0, 8'h0C, 1'b0, 1'b0);   // read code
        bus_write(16'hDEC0, 8'h0C, 1'b1, 1'b0);   // strobe inactive
        bus_write(16'hDEC0, 8'h0C, 1'b0, 1'b1);   // read direction
        bus_read(d);
        chk("R4 ignored writes", d, 8'hF3);
    endtask

    task automatic t_ma8_sweep();
        logic [15:0] pts [8] = '{16'h0000, 16'h03FF, 16'h0400, 16'h8000,
                                 16'hBFFF, 16'hC000, 16'hC7FF, 16'hC800};
        for (int en = 0; en < 4; en++) begin
            for (int bk = 0; bk < 4; bk++) begin
                logic [3:0] c;
                c = {en[1:0], bk[1:0]};
                bus_write(16'hDEC0, {4'h0, c}, 1'b0, 1'b0);
                for (int p = 0; p < 8; p++) begin
                    for (int s = 0; s < 2; s++) begin
                        @(negedge clk);
                        cpu_addr = pts[p]; mux_sel = s[0];
                        #1;
                        chk("R5 R6 R7 R8 ma8", {7'd0, ma8},
                            {7'd0, exp_ma8(c, pts[p], s[0])});
                    end
                end
            end
        end
        mux_sel = 1'b0; cpu_addr = 16'h8000;
    endtask

    task automatic t_reset_modes();
        logic [7:0] d;
        bus_write(16'hDEC0, 8'h0E, 1'b0, 1'b0);
        @(negedge clk); keep_cfg = 1'b1; rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        bus_read(d);
        chk("R9 preserve on", d, 8'hFE);
        @(negedge clk); keep_cfg = 1'b0; rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        bus_read(d);
        chk("R9 preserve off", d, 8'hF0);
    endtask

    task automatic t_clear_only();
        logic [7:0] d;
        bus_write(16'hDEC0, 8'h07, 1'b0, 1'b0);
        @(negedge clk); keep_cfg = 1'b1; clr_n = 1'b0;
        @(negedge clk); clr_n = 1'b1;
        bus_read(d);
        chk("R10 clear input", d, 8'hF0);
        keep_cfg = 1'b0;
    endtask

    initial begin : watchdog
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_readback();
        t_ignored();
        t_ma8_sweep();
        t_reset_modes();
        t_clear_only();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule